// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small microcontroller core leaves its running state and how deep it goes. When the CPU issues a wait-for-interrupt or wait-for-event request, the sequencer reads two depth bits and picks one of three states. Sleep gates only the CPU clock. Stop halts all core-domain clocks, the oscillators and the PLL, and can optionally move to the low-power regulator. Standby removes core-domain power.

The way the CPU entered a low-power state decides what may end it. A WFI entry waits for an enabled pending interrupt. A WFE entry waits for an event. A Stop exit goes through a start-up wait of fixed length before the clocks return, and it asks the clock tree to fall back to the internal RC oscillator. A Standby exit never resumes: it issues a one-cycle core reset with power restored and sets a sticky flag that software clears.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run. mode_o=0 (encoding: 0 Run, 1 Sleep, 2 Stop, 3 Standby). All clock, oscillator, PLL and core-power enables are 1. lp_reg_o, core_rst_o, force_hsi_o and sb_flag_o are 0.
- R2: A WFI or WFE request in Run with deep_sel_i=0 gives mode_o=1 on the next cycle. cpu_clk_en_o is 0, while per_clk_en_o, osc_en_o and pll_en_o stay 1.
- R3: A request with deep_sel_i=1 and pdown_sel_i=0 gives mode_o=2. Both clock enables, osc_en_o and pll_en_o are 0, and core_pwr_en_o is 1. lp_reg_o equals the lpreg_sel_i value sampled when the request was taken.
- R4: A request with deep_sel_i=1 and pdown_sel_i=1 gives mode_o=3, with core_pwr_en_o=0, core_rst_o=1 and every clock and oscillator enable at 0.
- R5: After a WFI entry, Sleep or Stop ends only when some bit of irq_pend_i & irq_en_i is 1. Events, and pending interrupts that are disabled, have no effect.
- R6: After a WFE entry, Sleep or Stop ends when any evt_i bit is 1. It also ends, while sev_on_pend_i=1, when any irq_pend_i bit goes from 0 to 1. A pending interrupt does not end a WFE wait while sev_on_pend_i=0.
- R7: An event seen in Run is latched. A WFE request taken while the latch is set, or while an event is present, keeps the block in Run. Every WFE request taken in Run clears the latch.
- R8: After the wake cycle of Stop, mode_o stays 2 with osc_en_o=1 and both clock enables 0 for MAIN_CYC+1 cycles (LP_CYC+1 if the low-power regulator was chosen). The block then returns to Run, and force_hsi_o is 1 for exactly that first Run cycle.
- R9: Standby ends only on a rising edge of wkpin_i while wkpin_en_i=1, a rising edge of rtc_alarm_i, ext_rst_i=1 or wdg_rst_i=1. The block then spends one cycle with core_rst_o=1 and core_pwr_en_o=1 (mode_o=3), then Run.
- R10: sb_flag_o is set by every Standby exit and cleared by flag_clr_i=1. If both happen in the same cycle, the set wins.
- R11: With sleep_on_exit_i=1, exc_return_i=1 in Run enters Sleep as a WFI entry. With sleep_on_exit_i=0, exc_return_i has no effect.
- R12: If WFI and WFE are requested in the same cycle, WFI wins: the entry is a WFI entry and the event latch is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deep_sel_i | input | 1 | Deep low-power select |
| pdown_sel_i | input | 1 | Power-down select for the deep state |
| lpreg_sel_i | input | 1 | Use the low-power regulator in Stop |
| sleep_on_exit_i | input | 1 | Re-enter Sleep on handler return |
| sev_on_pend_i | input | 1 | A newly pending interrupt counts as an event |
| wfi_req_i | input | 1 | Wait-for-interrupt request |
| wfe_req_i | input | 1 | Wait-for-event request |
| exc_return_i | input | 1 | Return from the last handler to thread mode |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Interrupt enables |
| evt_i | input | NEVT | Event lines |
| wkpin_en_i | input | 1 | Wakeup pin enable |
| wkpin_i | input | 1 | Wakeup pin |
| rtc_alarm_i | input | 1 | RTC alarm |
| ext_rst_i | input | 1 | External reset request |
| wdg_rst_i | input | 1 | Watchdog reset request |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the standby flag |
| mode_o | output | 2 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | High-speed oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| lp_reg_o | output | 1 | Low-power regulator selected |
| core_pwr_en_o | output | 1 | Core-domain power enable |
| core_rst_o | output | 1 | Core reset |
| force_hsi_o | output | 1 | Pulse: select the internal RC oscillator as system clock |
| sb_flag_o | output | 1 | Sticky standby-exit flag |

## Verification
The assertions assume that every input is synchronous to clk_i and stable around the rising edge. They also assume that MAIN_CYC and LP_CYC are at least 1. They do not assume that the CPU stops issuing requests while asleep, because the block ignores such requests. The bench changes every input only on the falling edge and holds each request or wake source for whole cycles. It keeps the wakeup pin and alarm low before each Standby entry, so that each rising edge it applies falls inside the Standby state.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_STOP, ST_WAKE, ST_STANDBY, ST_RST
  } pwr_state_e;

  localparam logic [1:0] MODE_RUN     = 2'd0;
  localparam logic [1:0] MODE_SLEEP   = 2'd1;
  localparam logic [1:0] MODE_STOP    = 2'd2;
  localparam logic [1:0] MODE_STANDBY = 2'd3;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NIRQ = 8,
  parameter int NEVT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NEVT-1:0] evt_i,
  input  logic            sev_on_pend_i,
  input  logic            wkpin_en_i,
  input  logic            wkpin_i,
  input  logic            rtc_alarm_i,
  input  logic            ext_rst_i,
  input  logic            wdg_rst_i,
  input  logic            run_i,
  input  logic            latch_clr_i,
  output logic            irq_wake_o,
  output logic            evt_now_o,
  output logic            evt_hit_o,
  output logic            sb_wake_o
);
  logic [NIRQ-1:0] pend_q;
  logic            wk_q, rtc_q, evt_latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      wk_q   <= 1'b0;
      rtc_q  <= 1'b0;
    end else begin
      pend_q <= irq_pend_i;
      wk_q   <= wkpin_i;
      rtc_q  <= rtc_alarm_i;
    end
  end

  // newly pended interrupts count as events only when enabled by sev_on_pend_i
  assign evt_now_o  = (|evt_i) | (sev_on_pend_i & |(irq_pend_i & ~pend_q));
  assign irq_wake_o = |(irq_pend_i & irq_en_i);
  assign sb_wake_o  = (wkpin_en_i & wkpin_i & ~wk_q) | (rtc_alarm_i & ~rtc_q)
                    | ext_rst_i | wdg_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  evt_latch_q <= 1'b0;
    else if (latch_clr_i)         evt_latch_q <= 1'b0;
    else if (evt_now_o && run_i)  evt_latch_q <= 1'b1;
  end

  assign evt_hit_o = evt_latch_q | evt_now_o;
endmodule

// File: rtl/pwr_start_timer.sv
module pwr_start_timer #(
  parameter int MAIN_CYC = 4,
  parameter int LP_CYC   = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic lp_i,
  output logic done_o
);
  localparam int MAXC = (LP_CYC > MAIN_CYC) ? LP_CYC : MAIN_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] MAIN_CNT = W'(MAIN_CYC);
  localparam logic [W-1:0] LP_CNT   = W'(LP_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= lp_i ? LP_CNT : MAIN_CNT;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter int NEVT     = 4,
  parameter int MAIN_CYC = 4,
  parameter int LP_CYC   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            deep_sel_i,
  input  logic            pdown_sel_i,
  input  logic            lpreg_sel_i,
  input  logic            sleep_on_exit_i,
  input  logic            sev_on_pend_i,
  input  logic            wfi_req_i,
  input  logic            wfe_req_i,
  input  logic            exc_return_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NEVT-1:0] evt_i,
  input  logic            wkpin_en_i,
  input  logic            wkpin_i,
  input  logic            rtc_alarm_i,
  input  logic            ext_rst_i,
  input  logic            wdg_rst_i,
  input  logic            flag_clr_i,
  output logic [1:0]      mode_o,
  output logic            cpu_clk_en_o,
  output logic            per_clk_en_o,
  output logic            osc_en_o,
  output logic            pll_en_o,
  output logic            lp_reg_o,
  output logic            core_pwr_en_o,
  output logic            core_rst_o,
  output logic            force_hsi_o,
  output logic            sb_flag_o
);
  pwr_state_e state_q, state_d;
  logic       wfe_kind_q, wfe_kind_d;
  logic       lp_q, flag_q, force_q;
  logic       irq_wake, evt_now, evt_hit, sb_wake, tmr_done, tmr_load;
  logic       run, latch_clr, wake;
  pwr_state_e deep_target;

  assign run       = (state_q == ST_RUN);
  assign latch_clr = run & wfe_req_i & ~wfi_req_i;

  pwr_wake_qual #(.NIRQ(NIRQ), .NEVT(NEVT)) u_qual (
    .clk_i, .rst_ni, .irq_pend_i, .irq_en_i, .evt_i, .sev_on_pend_i,
    .wkpin_en_i, .wkpin_i, .rtc_alarm_i, .ext_rst_i, .wdg_rst_i,
    .run_i(run), .latch_clr_i(latch_clr),
    .irq_wake_o(irq_wake), .evt_now_o(evt_now), .evt_hit_o(evt_hit),
    .sb_wake_o(sb_wake)
  );

  pwr_start_timer #(.MAIN_CYC(MAIN_CYC), .LP_CYC(LP_CYC)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .lp_i(lp_q), .done_o(tmr_done)
  );

  assign wake        = wfe_kind_q ? evt_now : irq_wake;
  assign deep_target = !deep_sel_i ? ST_SLEEP : (pdown_sel_i ? ST_STANDBY : ST_STOP);
  assign tmr_load    = (state_q == ST_STOP) & wake;

  always_comb begin
    state_d    = state_q;
    wfe_kind_d = wfe_kind_q;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_req_i) begin
          state_d    = deep_target;
          wfe_kind_d = 1'b0;
        end else if (wfe_req_i) begin
          if (!evt_hit) begin
            state_d    = deep_target;
            wfe_kind_d = 1'b1;
          end
        end else if (exc_return_i && sleep_on_exit_i) begin
          state_d    = ST_SLEEP;
          wfe_kind_d = 1'b0;
        end
      end
      ST_SLEEP:   if (wake) state_d = ST_RUN;
      ST_STOP:    if (wake) state_d = ST_WAKE;
      ST_WAKE:    if (tmr_done) state_d = ST_RUN;
      ST_STANDBY: if (sb_wake) state_d = ST_RST;
      ST_RST:     state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      wfe_kind_q <= 1'b0;
      lp_q       <= 1'b0;
      force_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      wfe_kind_q <= wfe_kind_d;
      if (run) lp_q <= lpreg_sel_i;
      force_q    <= (state_q == ST_WAKE) & tmr_done;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   flag_q <= 1'b0;
    else if ((state_q == ST_STANDBY) && sb_wake)   flag_q <= 1'b1;
    else if (flag_clr_i)                           flag_q <= 1'b0;
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP:          mode_o = MODE_SLEEP;
      ST_STOP, ST_WAKE:  mode_o = MODE_STOP;
      ST_STANDBY, ST_RST: mode_o = MODE_STANDBY;
      default:           mode_o = MODE_RUN;
    endcase
  end

  assign cpu_clk_en_o  = run;
  assign per_clk_en_o  = run | (state_q == ST_SLEEP);
  assign osc_en_o      = run | (state_q == ST_SLEEP) | (state_q == ST_WAKE) | (state_q == ST_RST);
  assign pll_en_o      = run | (state_q == ST_SLEEP) | (state_q == ST_RST);
  assign lp_reg_o      = (state_q == ST_STOP) & lp_q;
  assign core_pwr_en_o = (state_q != ST_STANDBY);
  assign core_rst_o    = (state_q == ST_STANDBY) | (state_q == ST_RST);
  assign force_hsi_o   = force_q;
  assign sb_flag_o     = flag_q;

  a_r2_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wfi_req_i && !deep_sel_i) |=> (mode_o == MODE_SLEEP && per_clk_en_o && !cpu_clk_en_o));

  a_r4_standby_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wfi_req_i && deep_sel_i && pdown_sel_i) |=> (!core_pwr_en_o && core_rst_o));

  a_r7_wfe_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wfe_req_i && !wfi_req_i && evt_hit) |=> cpu_clk_en_o);

  a_r8_hold_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && !tmr_done) |=> (!cpu_clk_en_o && !per_clk_en_o));

  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STANDBY && sb_wake) |=> (sb_flag_o && core_pwr_en_o && core_rst_o));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NIRQ = 8;
  localparam int NEVT = 4;
  localparam int MAIN_CYC = 4;
  localparam int LP_CYC = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic deep_sel_i = 0, pdown_sel_i = 0, lpreg_sel_i = 0, sleep_on_exit_i = 0, sev_on_pend_i = 0;
  logic wfi_req_i = 0, wfe_req_i = 0, exc_return_i = 0;
  logic [NIRQ-1:0] irq_pend_i = '0, irq_en_i = '0;
  logic [NEVT-1:0] evt_i = '0;
  logic wkpin_en_i = 0, wkpin_i = 0, rtc_alarm_i = 0, ext_rst_i = 0, wdg_rst_i = 0, flag_clr_i = 0;
  logic [1:0] mode_o;
  logic cpu_clk_en_o, per_clk_en_o, osc_en_o, pll_en_o, lp_reg_o, core_pwr_en_o, core_rst_o, force_hsi_o, sb_flag_o;

  always #10 clk_i = ~clk_i;

  pwr_mode_ctrl #(.NIRQ(NIRQ), .NEVT(NEVT), .MAIN_CYC(MAIN_CYC), .LP_CYC(LP_CYC)) uut (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run 1 sleep 2 stop 3 stop-startup 4 standby 5 reset-out
  int m_state, m_cnt;
  bit m_wfe, m_lp, m_latch, m_flag, m_force;
  logic [NIRQ-1:0] m_prev_pend;
  bit m_prev_wk, m_prev_rtc;

  function automatic int pick_depth();
    if (!deep_sel_i) return 1;
    if (!pdown_sel_i) return 2;
    return 4;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_wfe = 0; m_lp = 0; m_latch = 0; m_flag = 0; m_force = 0;
      m_prev_pend = '0; m_prev_wk = 0; m_prev_rtc = 0;
    end else begin
      bit ev, iw, sw, w;
      int ns;
      ev = (evt_i != 0) || (sev_on_pend_i && ((irq_pend_i & ~m_prev_pend) != 0));
      iw = (irq_pend_i & irq_en_i) != 0;
      sw = (wkpin_en_i && wkpin_i && !m_prev_wk) || (rtc_alarm_i && !m_prev_rtc) || ext_rst_i || wdg_rst_i;
      w  = m_wfe ? ev : iw;
      ns = m_state;
      m_force = (m_state == 3 && m_cnt == 0);
      if (m_state == 4 && sw) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
      case (m_state)
        0: begin
          m_lp = lpreg_sel_i;
          if (wfi_req_i) begin ns = pick_depth(); m_wfe = 0; end
          else if (wfe_req_i) begin
            if (!(m_latch || ev)) begin ns = pick_depth(); m_wfe = 1; end
          end else if (exc_return_i && sleep_on_exit_i) begin ns = 1; m_wfe = 0; end
          if (wfe_req_i && !wfi_req_i) m_latch = 0;
          else if (ev) m_latch = 1;
        end
        1: if (w) ns = 0;
        2: if (w) begin ns = 3; m_cnt = m_lp ? LP_CYC : MAIN_CYC; end
        3: if (m_cnt == 0) ns = 0; else m_cnt--;
        4: if (sw) ns = 5;
        default: ns = 0;
      endcase
      m_state = ns;
      m_prev_pend = irq_pend_i; m_prev_wk = wkpin_i; m_prev_rtc = rtc_alarm_i;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    int em;
    em = (m_state == 0) ? 0 : (m_state == 1) ? 1 : (m_state <= 3) ? 2 : 3;
    chk({cur_req, " mode"}, mode_o, em);
    chk({cur_req, " cpu_clk"}, cpu_clk_en_o, m_state == 0);
    chk({cur_req, " per_clk"}, per_clk_en_o, m_state <= 1);
    chk({cur_req, " osc"}, osc_en_o, m_state <= 1 || m_state == 3 || m_state == 5);
    chk({cur_req, " pll"}, pll_en_o, m_state <= 1 || m_state == 5);
    chk({cur_req, " lp_reg"}, lp_reg_o, m_state == 2 && m_lp);
    chk({cur_req, " core_pwr"}, core_pwr_en_o, m_state != 4);
    chk({cur_req, " core_rst"}, core_rst_o, m_state >= 4);
    chk({cur_req, " force_hsi"}, force_hsi_o, m_force);
    chk({cur_req, " flag"}, sb_flag_o, m_flag);
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_wfi(); wfi_req_i = 1; cyc(); wfi_req_i = 0; endtask
  task automatic pulse_wfe(); wfe_req_i = 1; cyc(); wfe_req_i = 0; endtask
  task automatic pulse_evt(input logic [NEVT-1:0] v); evt_i = v; cyc(); evt_i = '0; endtask
  task automatic pulse_irq(input logic [NIRQ-1:0] v); irq_pend_i = v; cyc(); irq_pend_i = '0; endtask

  initial begin
    int n;
    cyc(3);
    rst_ni = 1;
    cyc();
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o, pll_en_o, core_pwr_en_o}, 5'b11111);
    chk("R1 flags", {lp_reg_o, core_rst_o, force_hsi_o, sb_flag_o}, 0);

    // R2 / R5 sleep by WFI
    cur_req = "R2"; irq_en_i = 8'h01;
    pulse_wfi();
    chk("R2 sleep mode", mode_o, 1);
    chk("R2 gates", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b011);
    cur_req = "R5";
    pulse_evt(4'b0001);
    chk("R5 event ignored", mode_o, 1);
    irq_pend_i = 8'h02; cyc(2);
    chk("R5 disabled irq ignored", mode_o, 1);
    irq_pend_i = 8'h03; cyc();
    chk("R5 enabled irq wakes", mode_o, 0);
    irq_pend_i = '0; cyc();

    // R6 WFE wake
    cur_req = "R6";
    pulse_wfe();
    chk("R6 wfe sleep", mode_o, 1);
    irq_pend_i = 8'h01; cyc(2);
    chk("R6 irq w/o sev ignored", mode_o, 1);
    irq_pend_i = '0; cyc();
    pulse_evt(4'b0100);
    chk("R6 event wakes", mode_o, 0);
    sev_on_pend_i = 1;
    pulse_wfe();
    chk("R6 wfe sleep again", mode_o, 1);
    irq_pend_i = 8'h10; cyc();
    chk("R6 new pend with sev wakes", mode_o, 0);
    sev_on_pend_i = 0; irq_pend_i = '0; cyc();

    // R7 event latch
    cur_req = "R7";
    pulse_evt(4'b1000);
    pulse_wfe();
    chk("R7 latched event returns", mode_o, 0);
    pulse_wfe();
    chk("R7 latch consumed", mode_o, 1);
    pulse_evt(4'b0001);
    chk("R7 woke", mode_o, 0);

    // R3 / R8 stop, main regulator
    cur_req = "R3"; deep_sel_i = 1; lpreg_sel_i = 0;
    pulse_wfi();
    chk("R3 stop mode", mode_o, 2);
    chk("R3 stop gates", {cpu_clk_en_o, per_clk_en_o, osc_en_o, pll_en_o, core_pwr_en_o, lp_reg_o}, 6'b000010);
    cur_req = "R8";
    pulse_irq(8'h01);
    n = 0;
    while (mode_o == 2 && n < 100) begin
      if (osc_en_o !== 1'b1 || cpu_clk_en_o !== 1'b0) chk("R8 startup outputs", 0, 1);
      n++; cyc();
    end
    chk("R8 main startup length", n, MAIN_CYC + 1);
    chk("R8 force_hsi on first run", force_hsi_o, 1);
    cyc();
    chk("R8 force_hsi one cycle", force_hsi_o, 0);

    // stop with low-power regulator, WFE entry
    cur_req = "R3"; lpreg_sel_i = 1;
    pulse_wfe();
    chk("R3 lp regulator", lp_reg_o, 1);
    cur_req = "R8";
    pulse_evt(4'b0010);
    n = 0;
    while (mode_o == 2 && n < 100) begin n++; cyc(); end
    chk("R8 lp startup length", n, LP_CYC + 1);
    lpreg_sel_i = 0;

    // R4 / R9 / R10 standby
    cur_req = "R4"; pdown_sel_i = 1;
    pulse_wfi();
    chk("R4 standby", {mode_o, core_pwr_en_o, core_rst_o, osc_en_o}, {2'd3, 3'b010});
    cur_req = "R9";
    wkpin_i = 1; cyc(2);
    chk("R9 disabled pin ignored", mode_o, 3);
    chk("R9 still unpowered", core_pwr_en_o, 0);
    wkpin_i = 0; cyc();
    pulse_irq(8'h01);
    chk("R9 irq ignored", core_pwr_en_o, 0);
    wkpin_en_i = 1; wkpin_i = 1; cyc();
    chk("R9 reset pulse", {core_rst_o, core_pwr_en_o, sb_flag_o}, 3'b111);
    cyc();
    chk("R9 back to run", {mode_o, core_rst_o}, 0);
    wkpin_i = 0; wkpin_en_i = 0;
    cur_req = "R10";
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    chk("R10 w1c", sb_flag_o, 0);
    cur_req = "R9";
    pulse_wfi();
    rtc_alarm_i = 1; cyc();
    chk("R9 rtc exit", {core_rst_o, core_pwr_en_o, sb_flag_o}, 3'b111);
    rtc_alarm_i = 0; cyc();
    pulse_wfi();
    ext_rst_i = 1; cyc(); ext_rst_i = 0;
    chk("R9 ext reset exit", core_pwr_en_o, 1);
    cyc();
    cur_req = "R10";
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    chk("R10 cleared", sb_flag_o, 0);
    pulse_wfi();
    wdg_rst_i = 1; flag_clr_i = 1; cyc(); wdg_rst_i = 0; flag_clr_i = 0;
    chk("R10 set wins", sb_flag_o, 1);
    chk("R9 watchdog exit", core_pwr_en_o, 1);
    cyc();
    deep_sel_i = 0; pdown_sel_i = 0;

    // R11 sleep on exit
    cur_req = "R11";
    exc_return_i = 1; cyc(); exc_return_i = 0;
    chk("R11 no effect when off", mode_o, 0);
    sleep_on_exit_i = 1;
    exc_return_i = 1; cyc(); exc_return_i = 0;
    chk("R11 re-enter sleep", mode_o, 1);
    pulse_evt(4'b0001);
    chk("R11 wfi-kind ignores event", mode_o, 1);
    pulse_irq(8'h01);
    chk("R11 irq wakes", mode_o, 0);
    sleep_on_exit_i = 0;

    // R12 priority
    cur_req = "R12";
    pulse_evt(4'b0001);
    wfi_req_i = 1; wfe_req_i = 1; cyc(); wfi_req_i = 0; wfe_req_i = 0;
    chk("R12 wfi wins, sleeps", mode_o, 1);
    pulse_evt(4'b0001);
    chk("R12 wfi kind ignores event", mode_o, 1);
    pulse_irq(8'h01);
    chk("R12 wake", mode_o, 0);
    pulse_wfe();
    chk("R12 latch kept", mode_o, 0);
    cyc(2);
    finish_run();
  end
endmodule